// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block steps a flat panel and the serial video link that feeds it through a fixed bring-up and shut-down order. On a power-on request it first switches on panel power with the backlight dark and the link held in power-down, waits for the panel rail to ramp and settle, releases the link power-down, and lets the video source run with black pixels forced for a lock interval. Only then are real pixels let through, and only after that is the backlight lit.

A power-off request reverses the order. The backlight goes dark first and a backlight-off wait follows. Black video is then forced for more than a programmed number of whole frames, counted on a frame-start pulse. After that the link goes back into power-down, the video source is disabled and panel power is removed. Every wait is a parameter counted in ticks of a timebase input. A power-off request that arrives during bring-up lets the current step run out. The sequence then joins the shut-down path at the point whose outputs match, so no output ever moves backwards out of order. A single status output is high in the fully-off and fully-on states.

Top module: `panel_pwr_seq`

## Requirements
- R1: During and right after reset all five control outputs are low and `seq_done` is high (fully off).
- R2: A `pwr_on_req` sampled while fully off raises `panel_pwr_en` in the next cycle, with `link_pd_n`, `video_en`, `force_black`, `backlight_en` and `seq_done` low.
- R3: `link_pd_n`, `video_en` and `force_black` rise together exactly RAMP_CYC + SETTLE_CYC ticks after `panel_pwr_en` rose.
- R4: `force_black` falls LOCK_CYC ticks after the link was enabled while `video_en` stays high; `backlight_en` and `seq_done` rise IMAGE_CYC ticks later.
- R5: A `pwr_off_req` sampled while fully on drops `backlight_en` and `seq_done` in the next cycle; `force_black` rises BLOFF_CYC ticks later.
- R6: Black stays forced until the (BLACK_FRAMES+1)-th `frame_start` pulse sampled during the black step; `link_pd_n` falls in the cycle after that pulse. Pulses before the black step are not counted.
- R7: `video_en` and `force_black` fall GAP_CYC ticks after `link_pd_n` fell; `panel_pwr_en` falls GAP_CYC ticks later, and `seq_done` rises with it.
- R8: A `pwr_off_req` during the ramp or settle step lets that step finish, keeps only `panel_pwr_en` high for GAP_CYC more ticks and then returns to fully off; link and video never turn on.
- R9: A `pwr_off_req` during the black-lock or image step lets that step finish and then continues as in R6 and R7 from the black step; the backlight never turns on.
- R10: While `tick` is low no wait advances; each low-tick cycle lengthens the current timed step by one cycle.
- R11: `pwr_on_req` outside the fully-off state and `pwr_off_req` in the fully-off state or on the shut-down path have no effect.
- R12: `backlight_en` high implies `panel_pwr_en`, `link_pd_n` and `video_en` high and `force_black` low; `link_pd_n` or `video_en` high implies `panel_pwr_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase enable; all waits count cycles with tick high |
| pwr_on_req | input | 1 | Single-cycle request to bring the panel up |
| pwr_off_req | input | 1 | Single-cycle request to take the panel down |
| frame_start | input | 1 | Single-cycle pulse at the start of each video frame |
| panel_pwr_en | output | 1 | Panel supply enable |
| link_pd_n | output | 1 | Serial link power-down, active low (high = link running) |
| video_en | output | 1 | Video source output enable |
| force_black | output | 1 | Replace pixel data with black |
| backlight_en | output | 1 | Backlight enable |
| seq_done | output | 1 | High when fully off or fully on |

## Verification
Every output is a decode of the registered step, so a request sampled at a clock edge shows its first output change one cycle later, and a timed step of N ticks holds its outputs for exactly N cycles when `tick` stays high. The frame-counted black step ends in the cycle after the edge that samples the deciding `frame_start` pulse. The bench computes, for each stimulus, the absolute cycle of each expected output change from these rules and queues them. A monitor samples the outputs on the falling clock edge and compares every change with the head of the queue, so both the order of the changes and their exact spacing are checked, and any change that was not queued is reported.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_RAMP,
    ST_SETTLE,
    ST_LOCK,
    ST_IMAGE,
    ST_ON,
    ST_BLOFF,
    ST_BLACK,
    ST_LINKOFF,
    ST_SRCOFF
  } pps_state_e;

  typedef struct packed {
    logic panel;
    logic link;
    logic video;
    logic black;
    logic bl;
    logic done;
  } pps_out_t;

  // Output levels of every step.
  function automatic pps_out_t pps_decode(pps_state_e s);
    pps_out_t o;
    o = '{panel: 1'b0, link: 1'b0, video: 1'b0, black: 1'b0, bl: 1'b0, done: 1'b0};
    case (s)
      ST_OFF:     o.done = 1'b1;
      ST_RAMP,
      ST_SETTLE,
      ST_SRCOFF:  o.panel = 1'b1;
      ST_LOCK,
      ST_BLACK:   begin o.panel = 1'b1; o.link = 1'b1; o.video = 1'b1; o.black = 1'b1; end
      ST_IMAGE,
      ST_BLOFF:   begin o.panel = 1'b1; o.link = 1'b1; o.video = 1'b1; end
      ST_ON:      begin o.panel = 1'b1; o.link = 1'b1; o.video = 1'b1; o.bl = 1'b1; o.done = 1'b1; end
      ST_LINKOFF: begin o.panel = 1'b1; o.video = 1'b1; o.black = 1'b1; end
      default:    o.done = 1'b1;
    endcase
    return o;
  endfunction

  // Steps of the bring-up path, where an off request is held pending.
  function automatic logic pps_on_rise_path(pps_state_e s);
    return (s == ST_RAMP) || (s == ST_SETTLE) || (s == ST_LOCK) || (s == ST_IMAGE);
  endfunction

  // Steps whose length is a tick count.
  function automatic logic pps_is_timed(pps_state_e s);
    return (s != ST_OFF) && (s != ST_ON) && (s != ST_BLACK);
  endfunction

  // Shut-down step whose outputs match a bring-up step that has just ended.
  function automatic pps_state_e pps_join_point(pps_state_e s);
    return ((s == ST_RAMP) || (s == ST_SETTLE)) ? ST_SRCOFF : ST_BLACK;
  endfunction

  // Frame pulses needed so that more than `frames` whole frames are black.
  function automatic int unsigned pps_frames_needed(int unsigned frames);
    return frames + 1;
  endfunction

  // A step of `len` ticks ends on the tick that brings the count to len.
  function automatic logic pps_count_reaches(int unsigned cnt, int unsigned len);
    return (cnt + 1) >= len;
  endfunction

endpackage

// File: rtl/pps_step_timer.sv
module pps_step_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] len,
  output logic         done
);
  import pps_pkg::*;

  logic [W-1:0] cnt_q;
  logic         reach;

  assign reach = pps_count_reaches(int'(cnt_q), int'(len));
  assign done  = en && tick && reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (restart)               cnt_q <= '0;
    else if (en && tick && !reach)  cnt_q <= cnt_q + 1'b1;
  end

  // R10: a low tick freezes the wait count
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q));

  // R10: a step can only end on a tick
  p_end_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tick);

endmodule

// File: rtl/pps_frame_gate.sv
module pps_frame_gate #(
  parameter int unsigned FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic en,
  input  logic frame_start,
  output logic hit
);
  import pps_pkg::*;

  localparam int unsigned NEED = pps_frames_needed(FRAMES);
  localparam int unsigned FW   = $clog2(NEED + 1) + 1;

  logic [FW-1:0] fcnt_q;
  logic          reach;

  assign reach = pps_count_reaches(int'(fcnt_q), NEED);
  assign hit   = en && frame_start && reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           fcnt_q <= '0;
    else if (restart)                     fcnt_q <= '0;
    else if (en && frame_start && !reach) fcnt_q <= fcnt_q + 1'b1;
  end

  // R6: the black step ends only on a frame pulse inside that step
  p_hit_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (frame_start && en));

  // R6: outside the black step the pulse count stays cleared
  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart && $past(!en)) |-> (fcnt_q == '0));

endmodule

// File: rtl/pps_seq_fsm.sv
module pps_seq_fsm #(
  parameter int unsigned W          = 8,
  parameter int unsigned RAMP_CYC   = 4,
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned LOCK_CYC   = 4,
  parameter int unsigned IMAGE_CYC  = 4,
  parameter int unsigned BLOFF_CYC  = 4,
  parameter int unsigned GAP_CYC    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_on_req,
  input  logic                pwr_off_req,
  input  logic                step_done,
  input  logic                frames_hit,
  output pps_pkg::pps_state_e state_q,
  output logic                step_adv,
  output logic                timed_en,
  output logic                frame_en,
  output logic [W-1:0]        step_len
);
  import pps_pkg::*;

  pps_state_e state_d;
  logic       off_pend_q;
  logic       off_now;
  logic       off_pend_d;

  // pending off request while on the bring-up path
  assign off_now    = pps_on_rise_path(state_q) && (off_pend_q || pwr_off_req);
  assign off_pend_d = pps_on_rise_path(state_d) && off_now;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:     if (pwr_on_req) state_d = ST_RAMP;
      ST_RAMP:    if (step_done)  state_d = off_now ? pps_join_point(state_q) : ST_SETTLE;
      ST_SETTLE:  if (step_done)  state_d = off_now ? pps_join_point(state_q) : ST_LOCK;
      ST_LOCK:    if (step_done)  state_d = off_now ? pps_join_point(state_q) : ST_IMAGE;
      ST_IMAGE:   if (step_done)  state_d = off_now ? pps_join_point(state_q) : ST_ON;
      ST_ON:      if (pwr_off_req) state_d = ST_BLOFF;
      ST_BLOFF:   if (step_done)  state_d = ST_BLACK;
      ST_BLACK:   if (frames_hit) state_d = ST_LINKOFF;
      ST_LINKOFF: if (step_done)  state_d = ST_SRCOFF;
      ST_SRCOFF:  if (step_done)  state_d = ST_OFF;
      default:    state_d = ST_OFF;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_RAMP:    step_len = W'(RAMP_CYC);
      ST_SETTLE:  step_len = W'(SETTLE_CYC);
      ST_LOCK:    step_len = W'(LOCK_CYC);
      ST_IMAGE:   step_len = W'(IMAGE_CYC);
      ST_BLOFF:   step_len = W'(BLOFF_CYC);
      ST_LINKOFF,
      ST_SRCOFF:  step_len = W'(GAP_CYC);
      default:    step_len = '0;
    endcase
  end

  assign step_adv = (state_d != state_q);
  assign timed_en = pps_is_timed(state_q);
  assign frame_en = (state_q == ST_BLACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_OFF;
      off_pend_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      off_pend_q <= off_pend_d;
    end
  end

  // R2: only a request from the off state starts the ramp
  p_ramp_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RAMP && $past(state_q) != ST_RAMP) |-> ($past(state_q) == ST_OFF && $past(pwr_on_req)));

  // R11: on requests never disturb the fully-on state
  p_on_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ON && !pwr_off_req) |=> (state_q == ST_ON));

  // R8: an early abort lands on the panel-only shut-down step
  p_abort_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SRCOFF && $past(state_q) != ST_SRCOFF) |->
      ($past(state_q) == ST_LINKOFF || $past(state_q) == ST_SETTLE || $past(state_q) == ST_RAMP));

  // R9: the black step is reached from backlight-off or a finished lock/image step
  p_abort_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLACK && $past(state_q) != ST_BLACK) |->
      ($past(state_q) == ST_BLOFF || $past(state_q) == ST_LOCK || $past(state_q) == ST_IMAGE));

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int unsigned RAMP_CYC     = 500000,
  parameter int unsigned SETTLE_CYC   = 1000000,
  parameter int unsigned LOCK_CYC     = 110000,
  parameter int unsigned IMAGE_CYC    = 1000,
  parameter int unsigned BLOFF_CYC    = 100000,
  parameter int unsigned GAP_CYC      = 1000,
  parameter int unsigned BLACK_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_on_req,
  input  logic pwr_off_req,
  input  logic frame_start,
  output logic panel_pwr_en,
  output logic link_pd_n,
  output logic video_en,
  output logic force_black,
  output logic backlight_en,
  output logic seq_done
);
  import pps_pkg::*;

  localparam int unsigned M1 = (RAMP_CYC  > SETTLE_CYC) ? RAMP_CYC  : SETTLE_CYC;
  localparam int unsigned M2 = (LOCK_CYC  > IMAGE_CYC)  ? LOCK_CYC  : IMAGE_CYC;
  localparam int unsigned M3 = (BLOFF_CYC > GAP_CYC)    ? BLOFF_CYC : GAP_CYC;
  localparam int unsigned M4 = (M1 > M2) ? M1 : M2;
  localparam int unsigned MAX_CYC = (M4 > M3) ? M4 : M3;
  localparam int unsigned W  = $clog2(MAX_CYC + 1) + 1;

  pps_state_e   state;
  logic         step_adv;
  logic         timed_en;
  logic         frame_en;
  logic [W-1:0] step_len;
  logic         step_done;
  logic         frames_hit;
  pps_out_t     outs;

  pps_seq_fsm #(
    .W(W), .RAMP_CYC(RAMP_CYC), .SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC),
    .IMAGE_CYC(IMAGE_CYC), .BLOFF_CYC(BLOFF_CYC), .GAP_CYC(GAP_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .step_done(step_done), .frames_hit(frames_hit), .state_q(state),
    .step_adv(step_adv), .timed_en(timed_en), .frame_en(frame_en), .step_len(step_len)
  );

  pps_step_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(step_adv), .en(timed_en), .tick(tick),
    .len(step_len), .done(step_done)
  );

  pps_frame_gate #(.FRAMES(BLACK_FRAMES)) u_frames (
    .clk(clk), .rst_n(rst_n), .restart(step_adv), .en(frame_en),
    .frame_start(frame_start), .hit(frames_hit)
  );

  assign outs         = pps_decode(state);
  assign panel_pwr_en = outs.panel;
  assign link_pd_n    = outs.link;
  assign video_en     = outs.video;
  assign force_black  = outs.black;
  assign backlight_en = outs.bl;
  assign seq_done     = outs.done;

  // R12: backlight only over live, unmasked video
  p_bl_needs_image_r12: assert property (@(posedge clk) disable iff (!rst_n)
    backlight_en |-> (panel_pwr_en && link_pd_n && video_en && !force_black));

  // R12: link and source never run on an unpowered panel
  p_link_needs_panel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (link_pd_n || video_en) |-> panel_pwr_en);

  // R3: the link wakes up on a powered panel with black forced
  p_link_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_pd_n) |-> ($past(panel_pwr_en) && video_en && force_black));

  // R4: backlight follows unmasked video
  p_bl_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backlight_en) |-> ($past(video_en) && !$past(force_black)));

  // R5: backlight goes dark before black is forced again
  p_black_after_bl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(force_black) && $past(link_pd_n)) |-> !$past(backlight_en));

  // R6: the link sleeps only on a frame pulse, with black still forced
  p_link_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_pd_n) |-> ($past(frame_start) && force_black && !backlight_en));

  // R7: panel power goes last
  p_panel_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_pwr_en) |-> (!video_en && !link_pd_n && seq_done));

  // R1: the idle state shows all outputs off
  p_off_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !backlight_en) |-> (!panel_pwr_en && !video_en && !force_black));

endmodule

// File: tb/panel_pwr_seq_test.sv
`timescale 1ns/1ps
module panel_pwr_seq_test;

  localparam int R = 5;
  localparam int S = 7;
  localparam int L = 9;
  localparam int I = 4;
  localparam int B = 6;
  localparam int G = 3;
  localparam int F = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic pwr_on_req;
  logic pwr_off_req;
  logic frame_start;
  logic panel_pwr_en, link_pd_n, video_en, force_black, backlight_en, seq_done;
  logic [5:0] vec;

  always #2 clk = ~clk;

  panel_pwr_seq #(
    .RAMP_CYC(R), .SETTLE_CYC(S), .LOCK_CYC(L), .IMAGE_CYC(I),
    .BLOFF_CYC(B), .GAP_CYC(G), .BLACK_FRAMES(F)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_on_req(pwr_on_req),
    .pwr_off_req(pwr_off_req), .frame_start(frame_start),
    .panel_pwr_en(panel_pwr_en), .link_pd_n(link_pd_n), .video_en(video_en),
    .force_black(force_black), .backlight_en(backlight_en), .seq_done(seq_done)
  );

  // {panel, link, video, black, backlight, done}
  assign vec = {panel_pwr_en, link_pd_n, video_en, force_black, backlight_en, seq_done};

  typedef struct {
    logic [5:0] v;
    int         c;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  exp_t       it;
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 0;
  logic [5:0] prev = 6'b000001;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor: every output change must match the queue head
  always @(negedge clk) begin
    if (rst_n && vec !== prev) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11/R12 unexpected change at cycle %0d: actual %b expected %b", cyc, vec, prev);
      end else begin
        it = exp_q.pop_front();
        if (it.v !== vec || it.c != cyc) begin
          errors++;
          $display("FAIL %s: actual %b at cycle %0d, expected %b at cycle %0d", it.tag, vec, cyc, it.v, it.c);
        end
      end
    end
    prev = vec;
  end

  task automatic push(input logic [5:0] v, input int c, input string tag);
    exp_t e;
    e.v = v; e.c = c; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // 0: on request, 1: off request, 2: frame pulse
  task automatic pulse(input int which);
    case (which)
      0: pwr_on_req  = 1'b1;
      1: pwr_off_req = 1'b1;
      default: frame_start = 1'b1;
    endcase
    @(negedge clk);
    pwr_on_req = 1'b0; pwr_off_req = 1'b0; frame_start = 1'b0;
  endtask

  task automatic check_now(input logic [5:0] v, input string tag);
    checks++;
    if (vec !== v) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, vec, v);
    end
  endtask

  task automatic check_drained(input string tag);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d pending changes expected 0", tag, exp_q.size());
    end
  endtask

  // bring-up; h low-tick cycles inserted during the ramp step
  task automatic run_up(input int h);
    int k;
    int e;
    k = cyc;
    e = k + 1 + R + S + h;
    push(6'b100000, k + 1, "R2 panel on");
    push(6'b111100, e, "R3 link, video, black");
    push(6'b111000, e + L, "R4 black released");
    push(6'b111011, e + L + I, "R4 backlight on");
    pulse(0);
    if (h > 0) begin
      wait_until(k + 2);
      tick = 1'b0;
      wait_until(k + 2 + h);
      tick = 1'b1;
    end
    wait_until(e + 2);
    pulse(0); // R11: ignored on request during lock
    wait_until(e + L + I + 3);
    pulse(0); // R11: ignored on request while fully on
    wait_until(e + L + I + 6);
    check_now(6'b111011, "R4 fully on");
    check_drained("R4 up sequence complete");
  endtask

  // normal shut-down from fully on
  task automatic run_down();
    int k;
    int b;
    k = cyc;
    b = k + 1 + B;
    push(6'b111000, k + 1, "R5 backlight off");
    push(6'b111100, b, "R5 black forced");
    push(6'b101100, b + 11, "R6 link power-down");
    push(6'b100000, b + 11 + G, "R7 video off");
    push(6'b000001, b + 11 + 2 * G, "R7 panel off");
    pulse(1);
    wait_until(k + 2);
    pulse(2); // R6: before the black step, not counted
    wait_until(b + 2);
    pulse(2);
    wait_until(b + 4);
    pulse(0); // R11: on request on the shut-down path
    wait_until(b + 6);
    pulse(2);
    wait_until(b + 10);
    pulse(2);
    wait_until(b + 11 + 2 * G + 3);
    check_now(6'b000001, "R7 fully off");
    check_drained("R7 down sequence complete");
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1;
    pwr_on_req = 1'b0; pwr_off_req = 1'b0; frame_start = 1'b0;
    repeat (3) @(negedge clk);
    check_now(6'b000001, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_now(6'b000001, "R1 after reset");

    run_up(0);
    run_down();

    // R11: off request while fully off
    pulse(1);
    repeat (5) @(negedge clk);
    check_now(6'b000001, "R11 off ignored when off");

    // R8: off during settle
    begin
      int k;
      k = cyc;
      push(6'b100000, k + 1, "R2 panel on");
      push(6'b000001, k + 1 + R + S + G, "R8 early abort to off");
      pulse(0);
      wait_until(k + R + 2);
      pulse(1);
      wait_until(k + 1 + R + S + G + 3);
      check_now(6'b000001, "R8 off after early abort");
      check_drained("R8 early abort complete");
    end

    // R9: off during lock
    begin
      int k;
      int e;
      int bk;
      k  = cyc;
      e  = k + 1 + R + S;
      bk = e + L;
      push(6'b100000, k + 1, "R2 panel on");
      push(6'b111100, e, "R3 link on");
      push(6'b101100, bk + 6, "R9 link power-down after frames");
      push(6'b100000, bk + 6 + G, "R9 video off");
      push(6'b000001, bk + 6 + 2 * G, "R9 panel off");
      pulse(0);
      wait_until(e + 2);
      pulse(1);
      wait_until(e + 4);
      pulse(2); // R6: during lock, not counted
      wait_until(bk + 1);
      pulse(2);
      wait_until(bk + 3);
      pulse(2);
      wait_until(bk + 5);
      pulse(2);
      wait_until(bk + 6 + 2 * G + 3);
      check_now(6'b000001, "R9 off after late abort");
      check_drained("R9 late abort complete");
    end

    // R10: tick held low for four cycles during the ramp
    run_up(4);
    run_down();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1..R12 watchdog: actual cycle %0d expected completion earlier", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule